// File: doc/BRIEF.md
# Indexed Load Address and Data Unit

This block carries out one already-decoded 32-bit load of a word or an unsigned byte. It forms the byte offset either from a 12-bit immediate or from an index register passed through a barrel shifter. It adds that offset to the base register value, or subtracts it, and picks either the base or the sum as the access address. The block then makes a single read over a request/valid memory port and returns the data to the destination register, rotating an unaligned word and zero-extending a byte.

The caller supplies the instruction word, the base and index register values, the instruction address, the carry flag and a user-mode indication, and raises `start` for one cycle. The unit then presents a word-aligned read and waits for the memory to answer. In the cycle after the answer it raises the destination write strobe, together with the base writeback strobe when one is due. In the cycle after that it pulses `done` and returns to idle. A `start` that arrives while an operation is in progress is dropped. Condition evaluation, the register file, stores and halfword or signed loads belong to other blocks.

Top module: `ldst_load_unit`

## Requirements
- R1: The instruction is decoded with the register-form flag at bit 25, pre-index at 24, add/subtract at 23, byte at 22 and the W flag at 21. The base index is at 19:16 and the destination index at 15:12. When bit 25 is 0, bits 11:0 are an unsigned byte offset that is added to the base when bit 23 is 1 and subtracted when it is 0.
- R2: When bit 25 is 1, the offset is the index register value (register number in bits 3:0). It is shifted by the amount in bits 11:7 using the kind in bits 6:5: 00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right. A zero amount with kind 00 passes the value unchanged.
- R3: A zero shift amount with kind 01 yields 0. With kind 10 it yields 32 copies of bit 31. With kind 11 it gives a one-bit rotate through carry: the carry flag enters bit 31 and bits 31:1 move down.
- R4: With pre-index set, the access address is base ± offset, and that value is written back to the base register only when W is 1.
- R5: With pre-index clear, the access address is the unmodified base, and base ± offset is always written back to the base register.
- R6: When the base index is 15, the base value used is the instruction address plus 8.
- R7: The memory address is always word aligned. A word load from byte lane k returns the fetched word rotated right by 8·k bits, so the addressed byte sits in bits 7:0.
- R8: With the byte flag set, the result is the addressed byte in bits 7:0, and bits 31:8 are zero.
- R9: `acc_user` is 1 when `user_mode` is 1, or when pre-index is clear and W is 1. It is 0 otherwise, and stays 0 in particular for a pre-indexed access with W = 1.
- R10: In a form that writes back, `unpred` is raised and no writeback is made when any of the following holds: the base index is 15, the destination index equals the base index, or it is a register form whose index register is 15 or equals the base index. The destination write still takes place.
- R11: `mem_rd` and `mem_addr` hold steady until `mem_valid`. In the next cycle `rd_we` pulses once, together with `rn_we` when a writeback is due. `done` pulses in the following cycle, and a `start` seen before the unit is idle again is ignored.
- R12: After reset, `mem_rd`, `rd_we`, `rn_we` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the presented instruction when idle |
| instr | input | 32 | Decoded load instruction word |
| base_val | input | 32 | Value of the base register |
| rm_val | input | 32 | Value of the index register |
| iaddr | input | 32 | Address of the instruction |
| carry_in | input | 1 | Carry flag for the one-bit rotate |
| user_mode | input | 1 | Processor is already in user mode |
| mem_rd | output | 1 | Read request, held until answered |
| mem_addr | output | 32 | Word-aligned read address |
| mem_valid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data word |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 4 | Destination register number |
| rd_data | output | 32 | Aligned load result |
| rn_we | output | 1 | Base register writeback strobe |
| rn_idx | output | 4 | Base register number |
| rn_data | output | 32 | Writeback value |
| acc_user | output | 1 | Access is made with user privilege |
| unpred | output | 1 | Encoding is unpredictable; writeback suppressed |
| done | output | 1 | Operation complete pulse |

## Verification
The bench builds the unit with its default program-counter index of 15 and a read-ahead of 8. This lets the PC-relative base case and the PC-as-index unpredictable case be reached through the normal instruction fields. The bench's memory answers after a delay of zero to three cycles, chosen per operation, which exercises both the single-cycle response and the held request that waits through several cycles without an answer. The bench memory holds at each byte address the low eight bits of that address, so every rotation lane and every byte pick produces a distinct value.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 4;
    localparam int IMM_W  = 12;

    // instruction field positions that the decode depends on
    localparam int F_REG  = 25;
    localparam int F_PRE  = 24;
    localparam int F_ADD  = 23;
    localparam int F_BYTE = 22;
    localparam int F_WB   = 21;
    localparam int F_RN   = 16;
    localparam int F_RD   = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WR   = 2'd2,
        ST_DONE = 2'd3
    } ldu_state_e;

    typedef struct packed {
        ldu_state_e           st;
        logic [XLEN-1:0]      addr;
        logic [XLEN-1:0]      wbv;
        logic [XLEN-1:0]      data;
        logic                 is_byte;
        logic                 wb;
        logic                 unpred;
        logic                 acc_user;
        logic [RIDX_W-1:0]    rd_idx;
        logic [RIDX_W-1:0]    rn_idx;
    } ldu_regs_t;
endpackage

// File: rtl/ldu_offset_gen.sv
module ldu_offset_gen #(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic [IMM_W-1:0] low,
    input  logic             reg_form,
    input  logic [W-1:0]     rm,
    input  logic             carry,
    output logic [W-1:0]     offset
);
    localparam int SW = $clog2(W);

    logic [4:0]  sh;
    logic [1:0]  kind;
    logic [SW:0] inv;
    logic [W-1:0] shifted;

    assign sh   = low[11:7];
    assign kind = low[6:5];
    assign inv  = (SW+1)'(W) - {1'b0, sh};

    always_comb begin
        shifted = rm;
        unique case (kind)
            2'b00: shifted = rm << sh;
            2'b01: shifted = (sh == '0) ? '0 : (rm >> sh);
            2'b10: shifted = (sh == '0) ? {W{rm[W-1]}} : W'($signed(rm) >>> sh);
            2'b11: shifted = (sh == '0) ? {carry, rm[W-1:1]}
                                        : ((rm >> sh) | (rm << inv));
            default: shifted = rm;
        endcase
    end

    assign offset = reg_form ? shifted : {{(W-IMM_W){1'b0}}, low};
endmodule

// File: rtl/ldu_addr_calc.sv
module ldu_addr_calc #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] offset,
    input  logic         add,
    input  logic         pre,
    output logic [W-1:0] calc_addr,
    output logic [W-1:0] acc_addr
);
    assign calc_addr = add ? (base + offset) : (base - offset);
    assign acc_addr  = pre ? calc_addr : base;
endmodule

// File: rtl/ldu_load_align.sv
module ldu_load_align #(
    parameter int W = 32
) (
    input  logic [W-1:0]             rdata,
    input  logic [$clog2(W/8)-1:0]   lane,
    input  logic                     is_byte,
    output logic [W-1:0]             data
);
    localparam int SW = $clog2(W);

    logic [SW:0]  rs;
    logic [SW:0]  ls;
    logic [W-1:0] rot;

    assign rs   = {1'b0, lane, 3'b000};
    assign ls   = (SW+1)'(W) - rs;
    assign rot  = (rdata >> rs) | (rdata << ls);
    assign data = is_byte ? {{(W-8){1'b0}}, rot[7:0]} : rot;
endmodule

// File: rtl/ldst_load_unit.sv
module ldst_load_unit
    import ldu_pkg::*;
#(
    parameter int PC_REG   = 15,
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   rm_val,
    input  logic [XLEN-1:0]   iaddr,
    input  logic              carry_in,
    input  logic              user_mode,
    output logic              mem_rd,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rd_we,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_data,
    output logic              rn_we,
    output logic [RIDX_W-1:0] rn_idx,
    output logic [XLEN-1:0]   rn_data,
    output logic              acc_user,
    output logic              unpred,
    output logic              done
);
    localparam int LANE_W = $clog2(XLEN/8);
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(PC_REG);

    ldu_regs_t q, d;

    // field extraction
    logic              f_reg, f_pre, f_add, f_byte, f_w;
    logic [RIDX_W-1:0] f_rn, f_rd, f_rm;
    logic              unused_bits;

    assign f_reg  = instr[F_REG];
    assign f_pre  = instr[F_PRE];
    assign f_add  = instr[F_ADD];
    assign f_byte = instr[F_BYTE];
    assign f_w    = instr[F_WB];
    assign f_rn   = instr[F_RN +: RIDX_W];
    assign f_rd   = instr[F_RD +: RIDX_W];
    assign f_rm   = instr[RIDX_W-1:0];
    assign unused_bits = ^{instr[31:26], instr[20], instr[4]};

    logic [XLEN-1:0] base_eff, offset, calc_addr, acc_addr, aligned;
    logic            wb_form, bad_enc;

    assign base_eff = (f_rn == PC_IDX) ? (iaddr + XLEN'(PC_AHEAD)) : base_val;
    assign wb_form  = ~f_pre | f_w;
    assign bad_enc  = wb_form & ((f_rn == PC_IDX) | (f_rn == f_rd) |
                                 (f_reg & ((f_rm == PC_IDX) | (f_rm == f_rn))));

    ldu_offset_gen #(.W(XLEN), .IMM_W(IMM_W)) u_ofs (
        .low      (instr[IMM_W-1:0]),
        .reg_form (f_reg),
        .rm       (rm_val),
        .carry    (carry_in),
        .offset   (offset)
    );

    ldu_addr_calc #(.W(XLEN)) u_agen (
        .base      (base_eff),
        .offset    (offset),
        .add       (f_add),
        .pre       (f_pre),
        .calc_addr (calc_addr),
        .acc_addr  (acc_addr)
    );

    ldu_load_align #(.W(XLEN)) u_align (
        .rdata   (mem_rdata),
        .lane    (q.addr[LANE_W-1:0]),
        .is_byte (q.is_byte),
        .data    (aligned)
    );

    // next-state
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_REQ;
                    d.addr     = acc_addr;
                    d.wbv      = calc_addr;
                    d.is_byte  = f_byte;
                    d.unpred   = bad_enc;
                    d.wb       = wb_form & ~bad_enc;
                    d.acc_user = user_mode | (~f_pre & f_w);
                    d.rd_idx   = f_rd;
                    d.rn_idx   = f_rn;
                end
            end
            ST_REQ: begin
                if (mem_valid) begin
                    d.st   = ST_WR;
                    d.data = aligned;
                end
            end
            ST_WR:   d.st = ST_DONE;
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd   = (q.st == ST_REQ);
    assign mem_addr = {q.addr[XLEN-1:LANE_W], {LANE_W{1'b0}}};
    assign rd_we    = (q.st == ST_WR);
    assign rn_we    = (q.st == ST_WR) & q.wb;
    assign rd_idx   = q.rd_idx;
    assign rd_data  = q.data;
    assign rn_idx   = q.rn_idx;
    assign rn_data  = q.wbv;
    assign acc_user = q.acc_user;
    assign unpred   = q.unpred;
    assign done     = (q.st == ST_DONE);
endmodule

// File: rtl/ldu_checker.sv
module ldu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd,
    input logic        mem_valid,
    input logic [31:0] mem_addr,
    input logic        rd_we,
    input logic        rn_we,
    input logic        unpred,
    input logic        done
);
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_valid) |=> (mem_rd && $stable(mem_addr)));

    a_r11_write_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_valid) |=> rd_we);

    a_r11_wb_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rn_we |-> rd_we);

    a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |=> (done && !rd_we));

    a_r11_no_req_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> !mem_rd);

    a_r10_no_wb_when_unpred: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && unpred) |-> !rn_we);
endmodule

bind ldst_load_unit ldu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .rd_we     (rd_we),
    .rn_we     (rn_we),
    .unpred    (unpred),
    .done      (done)
);

// File: tb/sim_ldst_load_unit.sv
module sim_ldst_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0, base_val = '0, rm_val = '0, iaddr = '0;
    logic        carry_in = 1'b0, user_mode = 1'b0;
    logic        mem_rd, mem_valid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        rd_we, rn_we, acc_user, unpred, done;
    logic [3:0]  rd_idx, rn_idx;
    logic [31:0] rd_data, rn_data;

    int npass = 0, ntot = 0, lat_sel = 0, lat_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ldst_load_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_val(base_val), .rm_val(rm_val), .iaddr(iaddr),
        .carry_in(carry_in), .user_mode(user_mode),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_data(rd_data), .rn_we(rn_we), .rn_idx(rn_idx),
        .rn_data(rn_data), .acc_user(acc_user), .unpred(unpred), .done(done)
    );

    // memory: the byte at address X holds X[7:0]
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[7:0] + 8'd3, a[7:0] + 8'd2, a[7:0] + 8'd1, a[7:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_rd && !mem_valid) begin
            if (lat_cnt >= lat_sel) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                lat_cnt   <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_valid <= 1'b0;
        end
    end

    // expected load result from the requirements (R7, R8)
    function automatic logic [31:0] exp_load(input logic [31:0] ea, input bit is_byte);
        logic [31:0] r;
        if (is_byte) return {24'd0, ea[7:0]};
        for (int i = 0; i < 4; i++) r[8*i +: 8] = {ea[7:2], 2'(ea[1:0] + 2'(i))};
        return r;
    endfunction

    function automatic logic [31:0] mk(input bit i, p, u, b, w,
                                       input logic [3:0] rn, rd,
                                       input logic [11:0] lo);
        return {4'hE, 2'b01, i, p, u, b, w, 1'b1, rn, rd, lo};
    endfunction

    function automatic logic [11:0] sro(input logic [4:0] amt,
                                        input logic [1:0] kind,
                                        input logic [3:0] rm);
        return {amt, kind, 1'b0, rm};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] base;
        logic [31:0] rmv;
        logic [31:0] ia;
        logic        cy;
        logic        um;
        logic [31:0] ea;
        logic        rnwe;
        logic [31:0] rnv;
        logic        usr;
        logic        unp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R1 immediate, add, no writeback
        '{mk(0,1,1,0,0,4'd2,4'd1,12'h008), 32'h1000, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1008, 1'b0, 32'h0, 1'b0, 1'b0, "R1"},
        // R4 pre-index with writeback, subtract
        '{mk(0,1,0,0,1,4'd2,4'd1,12'h004), 32'h2000, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1FFC, 1'b1, 32'h1FFC, 1'b0, 1'b0, "R4"},
        // R5 post-index byte
        '{mk(0,0,1,1,0,4'd2,4'd1,12'h010), 32'h3001, 32'h0, 32'h0, 1'b0, 1'b0, 32'h3001, 1'b1, 32'h3011, 1'b0, 1'b0, "R5"},
        // R9 post-index with W forces user access, plain register offset
        '{mk(1,0,1,0,1,4'd2,4'd1,sro(5'd0,2'b00,4'd3)), 32'h4000, 32'h20, 32'h0, 1'b0, 1'b0, 32'h4000, 1'b1, 32'h4020, 1'b1, 1'b0, "R9"},
        // R2 shift left 2
        '{mk(1,1,1,0,0,4'd2,4'd1,sro(5'd2,2'b00,4'd3)), 32'h100, 32'h5, 32'h0, 1'b0, 1'b0, 32'h114, 1'b0, 32'h0, 1'b0, 1'b0, "R2"},
        // R3 logical right by zero -> 0
        '{mk(1,1,1,0,0,4'd2,4'd1,sro(5'd0,2'b01,4'd3)), 32'h500, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0, 32'h500, 1'b0, 32'h0, 1'b0, 1'b0, "R3"},
        // R7 arithmetic right by zero -> all ones, lane 3
        '{mk(1,1,1,0,0,4'd2,4'd1,sro(5'd0,2'b10,4'd3)), 32'h600, 32'h80000000, 32'h0, 1'b0, 1'b0, 32'h5FF, 1'b0, 32'h0, 1'b0, 1'b0, "R7"},
        // R3 rotate through carry, subtract, lane 2
        '{mk(1,1,0,0,0,4'd2,4'd1,sro(5'd0,2'b11,4'd3)), 32'h80000010, 32'h4, 32'h0, 1'b1, 1'b0, 32'h0000000E, 1'b0, 32'h0, 1'b0, 1'b0, "R3"},
        // R2 arithmetic right 4
        '{mk(1,1,1,0,0,4'd2,4'd1,sro(5'd4,2'b10,4'd3)), 32'h710, 32'hFFFFFF00, 32'h0, 1'b0, 1'b0, 32'h700, 1'b0, 32'h0, 1'b0, 1'b0, "R2"},
        // R2 rotate right 8
        '{mk(1,1,1,0,0,4'd2,4'd1,sro(5'd8,2'b11,4'd3)), 32'h01000020, 32'hFF, 32'h0, 1'b0, 1'b0, 32'h20, 1'b0, 32'h0, 1'b0, 1'b0, "R2"},
        // R8 byte load with logical right 4
        '{mk(1,1,1,1,0,4'd2,4'd1,sro(5'd4,2'b01,4'd3)), 32'h800, 32'h120, 32'h0, 1'b0, 1'b0, 32'h812, 1'b0, 32'h0, 1'b0, 1'b0, "R8"},
        // R6 PC base
        '{mk(0,1,1,0,0,4'd15,4'd1,12'h004), 32'hDEAD0000, 32'h0, 32'h9000, 1'b0, 1'b0, 32'h900C, 1'b0, 32'h0, 1'b0, 1'b0, "R6"},
        // R10 writeback with Rn == Rd
        '{mk(0,1,1,0,1,4'd2,4'd2,12'h004), 32'hA00, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA04, 1'b0, 32'h0, 1'b0, 1'b1, "R10"},
        // R10 post-index register form with Rn == Rm
        '{mk(1,0,1,0,0,4'd2,4'd1,sro(5'd0,2'b00,4'd2)), 32'hB00, 32'h10, 32'h0, 1'b0, 1'b0, 32'hB00, 1'b0, 32'h0, 1'b0, 1'b1, "R10"},
        // R9 already in user mode
        '{mk(0,1,1,0,0,4'd2,4'd1,12'h000), 32'hC00, 32'h0, 32'h0, 1'b0, 1'b1, 32'hC00, 1'b0, 32'h0, 1'b1, 1'b0, "R9"},
        // R10 writeback with PC as index register
        '{mk(1,1,1,0,1,4'd2,4'd1,sro(5'd0,2'b00,4'd15)), 32'hD00, 32'h8, 32'h0, 1'b0, 1'b0, 32'hD08, 1'b0, 32'h0, 1'b0, 1'b1, "R10"},
        // R5 post-index subtract largest immediate
        '{mk(0,0,0,0,0,4'd2,4'd1,12'hFFF), 32'h5000, 32'h0, 32'h0, 1'b0, 1'b0, 32'h5000, 1'b1, 32'h4001, 1'b0, 1'b0, "R5"},
        // R4 pre-index writeback with shift left 31
        '{mk(1,1,1,0,1,4'd2,4'd1,sro(5'd31,2'b00,4'd3)), 32'h10, 32'h3, 32'h0, 1'b0, 1'b0, 32'h80000010, 1'b1, 32'h80000010, 1'b0, 1'b0, "R4"}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (ok) npass++;
        else $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic drive(input vec_t v);
        instr = v.ins; base_val = v.base; rm_val = v.rmv;
        iaddr = v.ia; carry_in = v.cy; user_mode = v.um;
    endtask

    // runs one operation; optionally pulses a stray start during the request
    task automatic run_vec(input vec_t v, input int lat, input bit stray, input vec_t sv);
        logic [31:0] seen_addr = '0;
        int wr_cnt = 0, cyc = 0;
        bit got_done = 0, prev_we = 0, stray_sent = 0;
        string t = string'(v.tag);
        lat_sel = lat;
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && cyc < 40) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            start = 1'b0;
            if (mem_rd) begin
                seen_addr = mem_addr;
                if (stray && !stray_sent) begin
                    drive(sv);
                    start = 1'b1;
                    stray_sent = 1;
                end
            end
            if (rd_we) begin
                wr_cnt++;
                chk(rd_data == exp_load(v.ea, v.ins[22]), t, "rd_data", rd_data, exp_load(v.ea, v.ins[22]));
                chk(rd_idx == v.ins[15:12], t, "rd_idx", 32'(rd_idx), 32'(v.ins[15:12]));
                chk(rn_we == v.rnwe, t, "rn_we", 32'(rn_we), 32'(v.rnwe));
                if (v.rnwe) begin
                    chk(rn_data == v.rnv, t, "rn_data", rn_data, v.rnv);
                    chk(rn_idx == v.ins[19:16], t, "rn_idx", 32'(rn_idx), 32'(v.ins[19:16]));
                end
                chk(acc_user == v.usr, "R9", "acc_user", 32'(acc_user), 32'(v.usr));
                chk(unpred == v.unp, "R10", "unpred", 32'(unpred), 32'(v.unp));
            end
            if (done) begin
                got_done = 1;
                chk(prev_we, "R11", "done one cycle after rd_we", 32'(prev_we), 32'd1);
            end
            prev_we = rd_we;
        end
        start = 1'b0;
        chk(got_done, "R11", "done reached", 32'(got_done), 32'd1);
        chk(wr_cnt == 1, "R11", "rd_we pulses", 32'(wr_cnt), 32'd1);
        chk(seen_addr == {v.ea[31:2], 2'b00}, "R7", "mem_addr", seen_addr, {v.ea[31:2], 2'b00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            ntot++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", npass, ntot);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!mem_rd && !rd_we && !rn_we && !done, "R12", "outputs in reset",
            {28'd0, mem_rd, rd_we, rn_we, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd && !rd_we && !rn_we && !done, "R12", "outputs after reset",
            {28'd0, mem_rd, rd_we, rn_we, done}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i % 4, 1'b0, VEC[0]);

        // R11 start while busy is ignored
        run_vec(VEC[0], 3, 1'b1, VEC[1]);
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (mem_rd || rd_we) extra++;
            end
            chk(extra == 0, "R11", "activity after stray start", 32'(extra), 32'd0);
        end

        // R12 reset during a pending request
        lat_sel = 50;
        @(negedge clk);
        drive(VEC[4]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(mem_rd, "R11", "request pending", 32'(mem_rd), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_rd && !rd_we && !done, "R12", "outputs after mid reset",
            {29'd0, mem_rd, rd_we, done}, 32'd0);
        rst_n = 1'b1;
        lat_sel = 0;
        run_vec(VEC[11], 0, 1'b0, VEC[0]);

        finished = 1;
        $display("%0d/%0d checks passed", npass, ntot);
        $finish;
    end
endmodule